// File: doc/BRIEF.md
# Eight-Channel Serially Addressed Code Register Bank

This block is the digital control front end of an eight-channel, 8-bit converter. A host writes it through a three-wire serial port: a serial clock, an active-low select and a data line. While select is low, each rising serial clock edge shifts one data bit into an 11-bit shift register. The register is a window: only the 11 most recent bits are kept. When select rises, the held word is split into a 3-bit channel address and an 8-bit code, and the addressed channel register takes the code. The other seven channels keep their values.

The serial pins, the reset and the shutdown input are treated as asynchronous to the block clock `clk`. Each one passes through a two-stage synchronizer, and edges are detected in the `clk` domain. A small state machine runs the transfer. It has three states. `ST_IDLE` waits for select to fall, and the transition into the next state is called *open*. `ST_SHIFT` shifts on each detected serial clock rise and leaves on select rising, a transition called *close*. `ST_LOAD` lasts one cycle and issues the load strobe, then returns to idle through the transition called *commit*.

An asynchronous active-low reset puts every channel at mid-scale and empties the shift register. An active-low shutdown input lowers the output-enable flag. Shutdown leaves the channel codes unchanged and does not stop register writes.

Top module: `dacbank_top`

## Requirements
- R1: While select (`sel_n`) is high, serial clock edges do not change the shift register, so they have no effect on any channel.
- R2: While select is low, each rising `ser_clk` edge shifts the 11-bit register left by one and puts `ser_din` in bit 0. Words are sent MSB first.
- R3: When more than 11 bits are clocked in one select-low period, only the last 11 bits shifted in are kept.
- R4: A rising edge of select loads exactly one channel register. The channel is chosen by word bits [10:8], the first three bits sent. Value a selects channel index a, so 0 is the first channel and 7 is the eighth.
- R5: The loaded channel takes word bits [7:0], the last eight bits sent. All other channels keep their codes.
- R6: When fewer than 11 bits are clocked before select rises, the load still happens. It uses the shift register as it stands: older bits from earlier frames, or from reset, fill the upper positions.
- R7: While `midscale_rst_n` is low, all channel codes read 0x80 at once, with no clock edge needed. The shift register is cleared to zero.
- R8: While `pwrdn_n` is low, `out_en` is 0 and the codes are kept. Writes made during shutdown still update the channels. `out_en` returns to 1 after `pwrdn_n` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples all the serial pins |
| ser_clk | input | 1 | Serial shift clock; its rising edge is the active edge |
| sel_n | input | 1 | Active-low frame select; its rising edge commits the word |
| ser_din | input | 1 | Serial data, MSB first |
| midscale_rst_n | input | 1 | Asynchronous active-low reset to mid-scale |
| pwrdn_n | input | 1 | Active-low shutdown |
| chan_code | output | 8x8 | Packed channel codes; element i is channel index i |
| out_en | output | 1 | Output-enable flag, low during shutdown |

## Verification
The bench writes four codes into each of the eight channels, computed arithmetically, and compares all channels after every write. An address decoder with a stuck or swapped bit would therefore show up as the wrong channel changing. It also sends a 14-bit word and a 5-bit word. A register that kept the first bits instead of the last, or that cleared itself when a frame opened, would load the wrong channel or the wrong code. Serial clock toggles with select high, followed by an empty frame, catch a shift register that does not ignore idle clocks. A reset applied between clock edges, a 3-bit frame sent right after it, and a write made during shutdown catch a synchronous reset, a shift register that reset does not clear, and a shutdown that blocks writes.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;

    // Front-end transfer states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // select high, waiting for a frame
        ST_SHIFT = 2'd1,   // select low, shifting on serial clock rises
        ST_LOAD  = 2'd2    // one-cycle commit into a channel register
    } fe_state_t;

    localparam int DEF_NUM_CH   = 8;
    localparam int DEF_CODE_W   = 8;
    localparam int DEF_SYNC_STG = 2;

endpackage

// File: rtl/dacbank_sync.sv
module dacbank_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[s] <= RST_VAL;
                else        stg[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[s] <= RST_VAL;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/dacbank_serial.sv
module dacbank_serial
    import dacbank_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int CODE_W = 8,
    localparam int WORD_W = ADDR_W + CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              sel_n_s,
    input  logic              sdi_s,
    output fe_state_t         state,
    output logic [WORD_W-1:0] shreg,
    output logic              sclk_rise,
    output logic              load
);

    fe_state_t nxt;
    logic      sclk_q;

    // serial clock edge detect in the block clock domain
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_s;
    end
    assign sclk_rise = sclk_s & ~sclk_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions: open, close, commit
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (!sel_n_s) nxt = ST_SHIFT;   // open
            ST_SHIFT: if (sel_n_s)  nxt = ST_LOAD;    // close
            ST_LOAD:                nxt = ST_IDLE;    // commit
            default:                nxt = ST_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        load = 1'b0;
        unique case (state)
            ST_IDLE:  load = 1'b0;
            ST_SHIFT: load = 1'b0;
            ST_LOAD:  load = 1'b1;
            default:  load = 1'b0;
        endcase
    end

    // sliding window shift register, MSB first
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            shreg <= '0;
        else if (state == ST_SHIFT && sclk_rise)
            shreg <= {shreg[WORD_W-2:0], sdi_s};
    end

endmodule

// File: rtl/dacbank_chanregs.sv
module dacbank_chanregs #(
    parameter int NUM_CH = 8,
    parameter int CODE_W = 8,
    localparam int ADDR_W = $clog2(NUM_CH),
    localparam int WORD_W = ADDR_W + CODE_W,
    localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           load,
    input  logic [WORD_W-1:0]              word,
    output logic [NUM_CH-1:0]              load_vec,
    output logic [NUM_CH-1:0][CODE_W-1:0]  codes
);

    logic [ADDR_W-1:0] addr;
    logic [CODE_W-1:0] data;

    assign addr = word[WORD_W-1:CODE_W];
    assign data = word[CODE_W-1:0];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign load_vec[i] = load && (addr == ADDR_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           codes[i] <= MID;
            else if (load_vec[i]) codes[i] <= data;
        end
    end

endmodule

// File: rtl/dacbank_top.sv
module dacbank_top
    import dacbank_pkg::*;
#(
    parameter int NUM_CH   = DEF_NUM_CH,
    parameter int CODE_W   = DEF_CODE_W,
    parameter int SYNC_STG = DEF_SYNC_STG,
    localparam int ADDR_W = $clog2(NUM_CH),
    localparam int WORD_W = ADDR_W + CODE_W
) (
    input  logic                          clk,
    input  logic                          ser_clk,
    input  logic                          sel_n,
    input  logic                          ser_din,
    input  logic                          midscale_rst_n,
    input  logic                          pwrdn_n,
    output logic [NUM_CH-1:0][CODE_W-1:0] chan_code,
    output logic                          out_en
);

    logic [3:0]        pins_s;
    logic              sclk_s, sel_n_s, sdi_s, pwrdn_s;
    fe_state_t         state_w;
    logic [WORD_W-1:0] shreg_w;
    logic              sclk_rise_w;
    logic              load_w;
    logic [NUM_CH-1:0] load_vec_w;

    // bit order: serial clock, select, data, shutdown
    dacbank_sync #(
        .W       (4),
        .STAGES  (SYNC_STG),
        .RST_VAL (4'b0101)
    ) u_sync (
        .clk   (clk),
        .rst_n (midscale_rst_n),
        .d     ({ser_clk, sel_n, ser_din, pwrdn_n}),
        .q     (pins_s)
    );

    assign {sclk_s, sel_n_s, sdi_s, pwrdn_s} = pins_s;

    dacbank_serial #(
        .ADDR_W (ADDR_W),
        .CODE_W (CODE_W)
    ) u_serial (
        .clk       (clk),
        .rst_n     (midscale_rst_n),
        .sclk_s    (sclk_s),
        .sel_n_s   (sel_n_s),
        .sdi_s     (sdi_s),
        .state     (state_w),
        .shreg     (shreg_w),
        .sclk_rise (sclk_rise_w),
        .load      (load_w)
    );

    dacbank_chanregs #(
        .NUM_CH (NUM_CH),
        .CODE_W (CODE_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (midscale_rst_n),
        .load     (load_w),
        .word     (shreg_w),
        .load_vec (load_vec_w),
        .codes    (chan_code)
    );

    assign out_en = pwrdn_s;

endmodule

// File: rtl/dacbank_checker.sv
module dacbank_checker
    import dacbank_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CODE_W = 8,
    localparam int ADDR_W = $clog2(NUM_CH),
    localparam int WORD_W = ADDR_W + CODE_W
) (
    input logic                          clk,
    input logic                          rst_n,
    input fe_state_t                     state,
    input logic [WORD_W-1:0]             shreg,
    input logic                          sdi_s,
    input logic                          sclk_rise,
    input logic                          load,
    input logic [NUM_CH-1:0]             load_vec,
    input logic [NUM_CH-1:0][CODE_W-1:0] chan_code
);

    // R1: nothing is shifted while the frame is closed
    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> $stable(shreg));

    // R2: a serial clock rise in a frame shifts in the sampled data bit
    assert_shift_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && sclk_rise) |=>
            (shreg[0] == $past(sdi_s) && shreg[WORD_W-1:1] == $past(shreg[WORD_W-2:0])));

    // R4: at most one channel enable at a time, exactly one during commit
    assert_one_channel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_vec) && (load == ($countones(load_vec) == 1)));

    // R4: the commit strobe lasts a single cycle
    assert_single_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !load);

    // R5: codes change only on a commit
    assert_codes_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(chan_code));

endmodule

bind dacbank_top dacbank_checker #(
    .NUM_CH (NUM_CH),
    .CODE_W (CODE_W)
) u_checker (
    .clk       (clk),
    .rst_n     (midscale_rst_n),
    .state     (state_w),
    .shreg     (shreg_w),
    .sdi_s     (sdi_s),
    .sclk_rise (sclk_rise_w),
    .load      (load_w),
    .load_vec  (load_vec_w),
    .chan_code (chan_code)
);

// File: tb/tb_dacbank_top.sv
module tb_dacbank_top;

    logic            clk = 1'b0;
    logic            ser_clk = 1'b0;
    logic            sel_n = 1'b1;
    logic            ser_din = 1'b0;
    logic            midscale_rst_n = 1'b0;
    logic            pwrdn_n = 1'b1;
    logic [7:0][7:0] chan_code;
    logic            out_en;

    int checks = 0;
    int errors = 0;

    logic [7:0]  exp_code [8];
    logic [10:0] exp_sh;

    always #5 clk = ~clk;

    dacbank_top dut (
        .clk            (clk),
        .ser_clk        (ser_clk),
        .sel_n          (sel_n),
        .ser_din        (ser_din),
        .midscale_rst_n (midscale_rst_n),
        .pwrdn_n        (pwrdn_n),
        .chan_code      (chan_code),
        .out_en         (out_en)
    );

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bit(input logic b);
        ser_din = b;
        wait_n(4);
        ser_clk = 1'b1;
        wait_n(4);
        ser_clk = 1'b0;
        exp_sh = {exp_sh[9:0], b};
    endtask

    // one select-low period with n bits, MSB first
    task automatic frame(input int n, input logic [15:0] val);
        sel_n = 1'b0;
        wait_n(4);
        for (int i = n - 1; i >= 0; i--) shift_bit(val[i]);
        wait_n(4);
        sel_n = 1'b1;
        exp_code[int'(exp_sh[10:8])] = exp_sh[7:0];
        wait_n(10);
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < 8; i++) begin
            checks++;
            if (chan_code[i] !== exp_code[i]) begin
                errors++;
                $display("FAIL %s channel %0d: actual %h expected %h", req, i, chan_code[i], exp_code[i]);
            end
        end
    endtask

    task automatic check_en(input string req, input logic expv);
        checks++;
        if (out_en !== expv) begin
            errors++;
            $display("FAIL %s out_en: actual %b expected %b", req, out_en, expv);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) exp_code[i] = 8'h80;
        exp_sh = '0;
        wait_n(3);
        midscale_rst_n = 1'b1;
        wait_n(4);

        // R7 reset state, R8 enabled after reset
        check_all("R7 reset");
        check_en("R8 reset", 1'b1);

        // R4 R5 sweep: every channel, four codes each
        for (int k = 0; k < 4; k++) begin
            for (int ch = 0; ch < 8; ch++) begin
                logic [7:0] code;
                code = 8'((ch * 37 + k * 91 + 5) % 256);
                frame(11, {5'b0, 3'(ch), code});
                check_all("R4 R5 sweep");
            end
        end

        // R3 over-length word: 14 bits, last 11 count
        frame(14, 16'h3A5C);
        check_all("R3 overlength");

        // R6 short word: 5 bits on top of previous contents
        frame(5, 16'h0016);
        check_all("R6 short");

        // R1 serial clocks with select high are ignored
        ser_din = 1'b1;
        for (int t = 0; t < 6; t++) begin
            wait_n(3);
            ser_clk = 1'b1;
            wait_n(3);
            ser_clk = 1'b0;
        end
        frame(0, 16'h0000);
        check_all("R1 idle clocks");

        // R8 shutdown: flag low, codes kept, writes land
        pwrdn_n = 1'b0;
        wait_n(6);
        check_en("R8 shutdown", 1'b0);
        check_all("R8 codes kept");
        frame(11, {5'b0, 3'd6, 8'hC3});
        check_all("R8 write in shutdown");
        check_en("R8 still shut", 1'b0);
        pwrdn_n = 1'b1;
        wait_n(6);
        check_en("R8 wake", 1'b1);
        check_all("R8 after wake");

        // R7 asynchronous reset between edges
        #2 midscale_rst_n = 1'b0;
        #1;
        for (int i = 0; i < 8; i++) exp_code[i] = 8'h80;
        exp_sh = '0;
        check_all("R7 async");
        wait_n(2);
        midscale_rst_n = 1'b1;
        wait_n(4);
        // R7 shift register cleared: 3 bits give channel 0 code 0x05
        frame(3, 16'h0005);
        check_all("R7 cleared shift");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule